// File: doc/BRIEF.md
# Reference Delay Sweep Calibrator

This controller brings one slave converter into step with a master converter. The slave rebuilds its output data clock from a reference clock whose arrival is set by a programmable delay code. The controller walks that code upward from zero to its top value. At each code it watches the sampled slave data clock and marks the code as good or bad. When the sweep ends it programs the middle of the longest unbroken run of good codes.

It then tries the four quarter-period phase choices in order. It keeps the first choice under which the sampled slave clock equals the sampled master clock for a whole observation window. All programming goes out as single writes of one configuration word. At the end the controller raises `done`, and raises `err` as well if calibration failed.

Calibration order across a chain of slaves is left to the surrounding system. Each slave is calibrated only after the converter that feeds its reference clock has been set up.

Top module: `refdly_cal`

## Requirements
- R1: After reset, and until `start` is seen, `wr_en`, `done` and `err` are all 0.
- R2: A calibration run first writes the delay codes 0, 1, ... MAX_CODE in ascending order, each with phase 0. Every write goes to address 0xE. Its data word carries the delay code in bits [15 -: CODE_W], the phase select in bits 4:3, a 1 in bit 2 (slave mode), `!DRIVE_REF_OUT` in bit 1 and a 1 in bit 0. All other bits are 0.
- R3: A code counts as stable only if the slave clock shows exactly EXP_EDGES transitions in each of two back-to-back windows of WIN_LEN cycles. A clock that stalls high for part of a window therefore marks its code unstable.
- R4: The chosen code is floor((first + last) / 2), where first and last are the first and last stable codes of the longest run of consecutive stable codes. When two runs are equally long, the earlier run wins.
- R5: A stable run that is still open at MAX_CODE is closed with MAX_CODE as its last code.
- R6: After the sweep, the chosen code is written with phase 0, 1, 2, 3 in that order. Each write is followed by a window. The first phase whose window shows no sample where slave and master differ is kept; no further write follows, and the run ends with `done`=1 and `err`=0.
- R7: If no code is stable, the controller writes code 0 with phase 0 and ends with `done`=1 and `err`=1.
- R8: If none of the four phases matches, the controller writes code 0 with phase 0 after the fourth phase write, and ends with `done`=1 and `err`=1.
- R9: `done` and `err` hold, and no write is issued, until the next `start`. A `start` pulse that arrives during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a calibration run when the controller is idle or finished |
| slv_dclk | input | 1 | Sampled slave data clock |
| mst_dclk | input | 1 | Sampled master data clock |
| wr_en | output | 1 | Register write strobe toward the converter |
| wr_addr | output | ADDR_W | Register address of the write |
| wr_data | output | DATA_W | Configuration word of the write |
| done | output | 1 | Run finished |
| err | output | 1 | Run finished without a usable setting |

## Verification
The hardest case to reach from the ports is a code at the edge of a good region whose clock still toggles, only irregularly. Such a code must be rejected, or the midpoint shifts by one. The bench's converter model gives chosen codes next to the widest region a clock that is gated high for half of every 16 cycles. Those codes sit on one side only, so a misclassification moves the expected midpoint.

The model also offsets each good region by a further quarter period, as a real part does, and it can be forced never to match the master. These settings drive the phase search through its late-match and no-match outcomes, while a scoreboard compares every register write in order.

// File: rtl/refdly_pkg.sv
package refdly_pkg;

   typedef enum logic [3:0] {
      CAL_IDLE,
      CAL_SWEEP_WR,
      CAL_SWEEP_W1,
      CAL_SWEEP_W2,
      CAL_PICK,
      CAL_PHASE_WR,
      CAL_PHASE_WIN,
      CAL_FAIL_WR,
      CAL_END
   } cal_state_e;

   typedef enum logic [1:0] {
      WIN_IDLE,
      WIN_SETTLE,
      WIN_COUNT
   } win_state_e;

endpackage

// File: rtl/refdly_win.sv
module refdly_win
   import refdly_pkg::*;
#(
   parameter  int WIN_LEN = 256,
   parameter  int SETTLE  = 8,
   localparam int CW      = $clog2(WIN_LEN + 1),
   localparam int SW      = $clog2(SETTLE + 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          slv,
   input  logic          mst,
   output logic          done,
   output logic [CW-1:0] edges,
   output logic [CW-1:0] misses
);

   win_state_e    st;
   win_state_e    first_ph;
   logic [SW-1:0] scnt;
   logic [CW-1:0] wcnt;
   logic          slv_d;

   generate
      if (SETTLE == 0) begin : g_nosettle
         assign first_ph = WIN_COUNT;
      end else begin : g_settle
         assign first_ph = WIN_SETTLE;
      end
      if (WIN_LEN < 2) begin : g_bad_len
         initial $error("refdly_win: WIN_LEN must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= WIN_IDLE;
         scnt   <= '0;
         wcnt   <= '0;
         edges  <= '0;
         misses <= '0;
         done   <= 1'b0;
         slv_d  <= 1'b0;
      end else begin
         slv_d <= slv;
         done  <= 1'b0;
         if (go) begin
            st     <= first_ph;
            scnt   <= '0;
            wcnt   <= '0;
            edges  <= '0;
            misses <= '0;
         end else begin
            case (st)
               WIN_SETTLE: begin
                  if (scnt == SW'(SETTLE - 1)) st <= WIN_COUNT;
                  else                          scnt <= scnt + 1'b1;
               end
               WIN_COUNT: begin
                  if (slv != slv_d) edges  <= edges + 1'b1;
                  if (slv != mst)   misses <= misses + 1'b1;
                  if (wcnt == CW'(WIN_LEN - 1)) begin
                     st   <= WIN_IDLE;
                     done <= 1'b1;
                  end else begin
                     wcnt <= wcnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R3: a window can never report more transitions than it has cycles
   p_edges_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      edges <= CW'(WIN_LEN));

   // R6: a window ends exactly once
   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/refdly_runtrk.sv
module refdly_runtrk #(
   parameter  int CODE_W = 10,
   localparam int LW     = CODE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              upd,
   input  logic              stable,
   input  logic              at_max,
   input  logic [CODE_W-1:0] code,
   output logic              found,
   output logic [CODE_W-1:0] center
);

   logic [LW-1:0]     run_len, best_len, cand_len;
   logic [CODE_W-1:0] run_lo, best_lo, best_hi, cand_lo, cand_hi;
   logic [LW-1:0]     sum;
   logic              closing;

   always_comb begin
      cand_len = stable ? run_len + 1'b1 : run_len;
      cand_lo  = (stable && run_len == '0) ? code : run_lo;
      cand_hi  = stable ? code : code - 1'b1;
      closing  = !stable || at_max;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len  <= '0;
         run_lo   <= '0;
         best_len <= '0;
         best_lo  <= '0;
         best_hi  <= '0;
      end else if (clr) begin
         run_len  <= '0;
         run_lo   <= '0;
         best_len <= '0;
         best_lo  <= '0;
         best_hi  <= '0;
      end else if (upd) begin
         if (!closing) begin
            run_len <= cand_len;
            run_lo  <= cand_lo;
         end else begin
            run_len <= '0;
            if (cand_len > best_len) begin
               best_len <= cand_len;
               best_lo  <= cand_lo;
               best_hi  <= cand_hi;
            end
         end
      end
   end

   assign sum    = {1'b0, best_lo} + {1'b0, best_hi};
   assign center = sum[LW-1:1];
   assign found  = (best_len != '0);

   // R4: the recorded best run never shrinks within a run
   p_best_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> best_len >= $past(best_len));

   // R4: the midpoint lies inside the recorded run
   p_center_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (center >= best_lo && center <= best_hi));

   // R5: the last code always closes any open run
   p_max_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && at_max && !clr) |=> run_len == '0);

endmodule

// File: rtl/refdly_cal.sv
module refdly_cal
   import refdly_pkg::*;
#(
   parameter  int          CODE_W        = 10,
   parameter  int          MAX_CODE      = 639,
   parameter  int          WIN_LEN       = 256,
   parameter  int          EXP_EDGES     = 128,
   parameter  int          SETTLE        = 8,
   parameter  bit          DRIVE_REF_OUT = 1'b0,
   parameter  int          ADDR_W        = 4,
   parameter  int          DATA_W        = 16,
   parameter  logic [3:0]  CFG_ADDR      = 4'hE,
   localparam int          CW            = $clog2(WIN_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              slv_dclk,
   input  logic              mst_dclk,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              done,
   output logic              err
);

   generate
      if (MAX_CODE < 1 || MAX_CODE >= (1 << CODE_W)) begin : g_bad_max
         initial $error("refdly_cal: MAX_CODE must fit the code field");
      end
      if (CODE_W + 5 > DATA_W) begin : g_bad_field
         initial $error("refdly_cal: code field overlaps the control bits");
      end
      if (EXP_EDGES < 1 || EXP_EDGES > WIN_LEN) begin : g_bad_edges
         initial $error("refdly_cal: EXP_EDGES must lie in 1..WIN_LEN");
      end
   endgenerate

   function automatic logic [DATA_W-1:0] mk_word(input logic [CODE_W-1:0] c,
                                                 input logic [1:0] p);
      logic [DATA_W-1:0] w;
      w                   = '0;
      w[DATA_W-1 -: CODE_W] = c;
      w[4:3]              = p;
      w[2]                = 1'b1;
      w[1]                = !DRIVE_REF_OUT;
      w[0]                = 1'b1;
      return w;
   endfunction

   cal_state_e        st;
   logic [CODE_W-1:0] code;
   logic [1:0]        ph;
   logic              first_ok;
   logic              slv_q, mst_q;
   logic              win_go, win_done;
   logic [CW-1:0]     win_edges, win_misses;
   logic              trk_clr, trk_upd, stable_now, at_max, found;
   logic [CODE_W-1:0] center;
   logic              accept;

   assign wr_addr    = ADDR_W'(CFG_ADDR);
   assign accept     = start && (st == CAL_IDLE || st == CAL_END);
   assign trk_clr    = accept;
   assign trk_upd    = (st == CAL_SWEEP_W2) && win_done;
   assign stable_now = first_ok && (win_edges == CW'(EXP_EDGES));
   assign at_max     = (code == CODE_W'(MAX_CODE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slv_q <= 1'b0;
         mst_q <= 1'b0;
      end else begin
         slv_q <= slv_dclk;
         mst_q <= mst_dclk;
      end
   end

   refdly_win #(.WIN_LEN(WIN_LEN), .SETTLE(SETTLE)) i_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (win_go),
      .slv    (slv_q),
      .mst    (mst_q),
      .done   (win_done),
      .edges  (win_edges),
      .misses (win_misses)
   );

   refdly_runtrk #(.CODE_W(CODE_W)) i_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (trk_clr),
      .upd    (trk_upd),
      .stable (stable_now),
      .at_max (at_max),
      .code   (code),
      .found  (found),
      .center (center)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= CAL_IDLE;
         code     <= '0;
         ph       <= '0;
         first_ok <= 1'b0;
         wr_en    <= 1'b0;
         wr_data  <= '0;
         win_go   <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
      end else begin
         wr_en  <= 1'b0;
         win_go <= 1'b0;
         case (st)
            CAL_IDLE, CAL_END: begin
               if (st == CAL_END) done <= 1'b1;
               if (accept) begin
                  code <= '0;
                  ph   <= '0;
                  done <= 1'b0;
                  err  <= 1'b0;
                  st   <= CAL_SWEEP_WR;
               end
            end
            CAL_SWEEP_WR: begin
               wr_en   <= 1'b1;
               wr_data <= mk_word(code, 2'd0);
               win_go  <= 1'b1;
               st      <= CAL_SWEEP_W1;
            end
            CAL_SWEEP_W1: begin
               if (win_done) begin
                  first_ok <= (win_edges == CW'(EXP_EDGES));
                  win_go   <= 1'b1;
                  st       <= CAL_SWEEP_W2;
               end
            end
            CAL_SWEEP_W2: begin
               if (win_done) begin
                  if (at_max) begin
                     st <= CAL_PICK;
                  end else begin
                     code <= code + 1'b1;
                     st   <= CAL_SWEEP_WR;
                  end
               end
            end
            CAL_PICK: begin
               if (found) begin
                  code <= center;
                  ph   <= '0;
                  st   <= CAL_PHASE_WR;
               end else begin
                  st <= CAL_FAIL_WR;
               end
            end
            CAL_PHASE_WR: begin
               wr_en   <= 1'b1;
               wr_data <= mk_word(code, ph);
               win_go  <= 1'b1;
               st      <= CAL_PHASE_WIN;
            end
            CAL_PHASE_WIN: begin
               if (win_done) begin
                  if (win_misses == '0) begin
                     st <= CAL_END;
                  end else if (ph == 2'd3) begin
                     st <= CAL_FAIL_WR;
                  end else begin
                     ph <= ph + 1'b1;
                     st <= CAL_PHASE_WR;
                  end
               end
            end
            CAL_FAIL_WR: begin
               code    <= '0;
               ph      <= '0;
               wr_en   <= 1'b1;
               wr_data <= mk_word('0, 2'd0);
               err     <= 1'b1;
               st      <= CAL_END;
            end
            default: st <= CAL_IDLE;
         endcase
      end
   end

   // R2: no write ever carries a code beyond the top of the sweep
   p_code_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_data[DATA_W-1 -: CODE_W] <= CODE_W'(MAX_CODE));

   // R2: the sweep advances one code per classified step
   p_sweep_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CAL_SWEEP_W2 && win_done && !at_max) |=> code == $past(code) + 1'b1);

   // R7: a failed run leaves the delay code at zero
   p_fail_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CAL_END && err) |-> code == '0);

   // R9: once finished, the controller stays silent
   p_quiet_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_en);

endmodule

// File: tb/test_refdly_cal.sv
module test_refdly_cal;

   localparam int CODE_W = 10;
   localparam int MAXC   = 39;
   localparam int WLEN   = 16;

   logic        clk, rst_n, start, slv_dclk, mst_dclk;
   logic        wr_en, done, err;
   logic [3:0]  wr_addr;
   logic [15:0] wr_data;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;
   int cnt   = 0;

   logic [15:0] exp_q[$];
   string       tag_q[$];
   logic [15:0] cur_word = 16'h0003;

   // converter model configuration
   int nreg;
   int lo[3];
   int hi[3];
   int ilo, ihi, base;
   bit no_match;

   refdly_cal #(
      .CODE_W(CODE_W), .MAX_CODE(MAXC), .WIN_LEN(WLEN),
      .EXP_EDGES(WLEN / 2), .SETTLE(4)
   ) i_refdly_cal (
      .clk(clk), .rst_n(rst_n), .start(start),
      .slv_dclk(slv_dclk), .mst_dclk(mst_dclk),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .done(done), .err(err)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic logic [15:0] word(input int c, input int p);
      return 16'((c << 6) | (p << 3) | 7);
   endfunction

   task automatic push(input int c, input int p, input string tag);
      exp_q.push_back(word(c, p));
      tag_q.push_back(tag);
   endtask

   // monitor, converter model and watchdog
   always @(negedge clk) begin
      int  c, p, idx;
      bit  ok;
      logic [15:0] w;
      string t;
      cyc++;
      if (cyc > 150000) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d cycles expected=fewer", cyc);
         summary();
         $finish;
      end
      if (rst_n && wr_en) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R2 unexpected write: actual=%h expected=none", wr_data);
         end else begin
            w = exp_q.pop_front();
            t = tag_q.pop_front();
            if (wr_addr !== 4'hE || wr_data !== w) begin
               n_bad++;
               $display("FAIL %s: actual=%h:%h expected=e:%h", t, wr_addr, wr_data, w);
            end
         end
         cur_word = wr_data;
      end
      cnt++;
      c   = int'(cur_word[15:6]);
      p   = int'(cur_word[4:3]);
      ok  = 1'b0;
      idx = 0;
      for (int k = 0; k < nreg; k++)
         if (c >= lo[k] && c <= hi[k]) begin
            ok  = 1'b1;
            idx = k;
         end
      mst_dclk = ((cnt >> 1) & 1) != 0;
      if (ok) begin
         int off;
         off = no_match ? 2 : (idx + base + p) % 4;
         slv_dclk = (((cnt + off) >> 1) & 1) != 0;
      end else if (c >= ilo && c <= ihi) begin
         slv_dclk = ((cnt >> 3) & 1) != 0 ? 1'b1 : (((cnt >> 1) & 1) != 0);
      end else begin
         slv_dclk = 1'b1;
      end
   end

   task automatic cfg(input int n, input int l0, input int h0, input int l1, input int h1,
                      input int l2, input int h2, input int il, input int ih,
                      input int b, input bit nm);
      nreg = n; lo[0] = l0; hi[0] = h0; lo[1] = l1; hi[1] = h1; lo[2] = l2; hi[2] = h2;
      ilo = il; ihi = ih; base = b; no_match = nm;
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic run_case(input string tag, input bit mid_start);
      int  best, blen, ctr, pk, guard;
      bit  exp_err;
      string etag;
      best = -1;
      blen = 0;
      for (int c = 0; c <= MAXC; c++) push(c, 0, "R2 sweep");
      for (int k = 0; k < nreg; k++)
         if (hi[k] - lo[k] + 1 > blen) begin
            blen = hi[k] - lo[k] + 1;
            best = k;
         end
      if (best < 0) begin
         push(0, 0, "R7 no stable code");
         exp_err = 1'b1;
         etag = "R7 err";
      end else begin
         ctr = (lo[best] + hi[best]) / 2;
         if (no_match) begin
            for (int p = 0; p < 4; p++) push(ctr, p, "R8 phase try");
            push(0, 0, "R8 fallback");
            exp_err = 1'b1;
            etag = "R8 err";
         end else begin
            pk = (4 - ((best + base) % 4)) % 4;
            for (int p = 0; p <= pk; p++) push(ctr, p, tag);
            exp_err = 1'b0;
            etag = "R6 err";
         end
      end
      pulse_start();
      if (mid_start) begin
         repeat (200) @(negedge clk);
         start = 1'b1;
         @(negedge clk) start = 1'b0;
      end
      guard = 0;
      while (!done && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      chk(done == 1'b1, "R6 done raised", int'(done), 1);
      chk(exp_q.size() == 0, "R2 write sequence complete", exp_q.size(), 0);
      chk(err == exp_err, etag, int'(err), int'(exp_err));
      repeat (5) @(negedge clk);
      chk(done == 1'b1 && err == exp_err, "R9 result holds", int'({done, err}),
          int'({1'b1, exp_err}));
      exp_q.delete();
      tag_q.delete();
   endtask

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      slv_dclk = 1'b1;
      mst_dclk = 1'b0;
      cfg(0, 0, 0, 0, 0, 0, 0, 100, 100, 0, 1'b0);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(wr_en == 1'b0, "R1 wr_en idle", int'(wr_en), 0);
      chk(done == 1'b0, "R1 done idle", int'(done), 0);
      chk(err == 1'b0, "R1 err idle", int'(err), 0);

      // three regions, widest in the middle, irregular clock at 31..32
      cfg(3, 5, 12, 16, 30, 34, 39, 31, 32, 1, 1'b0);
      run_case("R3/R4 intermittent edge excluded, center 23", 1'b0);

      // widest run reaches the last code
      cfg(2, 2, 6, 20, 39, 0, 0, 100, 100, 3, 1'b0);
      run_case("R5 run closed at max, center 29", 1'b0);

      // equal-length runs: earlier wins
      cfg(2, 3, 10, 20, 27, 0, 0, 100, 100, 2, 1'b0);
      run_case("R4 tie keeps first, center 6", 1'b0);

      // nothing stable
      cfg(0, 0, 0, 0, 0, 0, 0, 100, 100, 0, 1'b0);
      run_case("R7", 1'b0);

      // stable but never in phase with the master
      cfg(3, 5, 12, 16, 30, 34, 39, 31, 32, 1, 1'b1);
      run_case("R8", 1'b0);

      // run from code 0, with a stray start mid-sweep
      cfg(1, 0, 9, 0, 0, 0, 0, 100, 100, 3, 1'b0);
      run_case("R9 mid-run start ignored, R6 center 4", 1'b1);

      summary();
      $finish;
   end

endmodule